// File: doc/BRIEF.md
# Direct-Mapped Branch Target Buffer

This block sits beside the fetch stage. It remembers where taken branches landed, so fetch can jump to the right place in the same cycle it reads a branch, before decode has even seen the instruction. Every cycle it takes the current fetch address and uses the low address bits to pick one row of a 64-row table. It then checks the tag held in that row against the high address bits. On a match it offers the stored landing address as the next fetch address. Otherwise it offers the sequential address, fetch address plus four.

The table is written only when a branch resolves as taken. The resolving address and its landing address go into the row that address selects, and whatever occupied that row before is replaced. The block holds destinations only. It never decides whether a branch will be taken. Lookup is purely combinational. A write takes effect at the next clock edge, so a lookup in the same cycle as a write still reads the old row contents. The block has no state machine: its only state is the table itself.

Top module: `btb_direct`

## Requirements
- R1: After reset every row is invalid, so every fetch address reports `lookup_hit` = 0 until a row is written.
- R2: On a miss, `next_pc` equals `fetch_pc` + 4 (modulo 2^32) and `predicted_target` is zero.
- R3: After a write with `update_valid` = 1, from the next cycle on, a lookup of the same word address reports `lookup_hit` = 1, with `predicted_target` and `next_pc` both equal to the written target.
- R4: The row is selected by address bits [7:2], giving 64 independent rows. Writing one row leaves every other row unchanged.
- R5: The tag is address bits [31:8]. A fetch address that selects a written row but carries a different tag reports a miss.
- R6: A write to a row that already holds another address replaces it. The previous address then misses, and the new one hits with the new target.
- R7: Address bits [1:0] take no part in row selection or tag comparison, neither on lookup nor on update. On a miss, the sum still uses the full `fetch_pc`.
- R8: When a write and a lookup select the same row in the same cycle, the lookup reports the row's contents from before the write. The new contents are seen from the next cycle.
- R9: While `update_valid` is 0, the values on `update_pc` and `update_target` change no row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; table writes happen on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; invalidates every row |
| fetch_pc | input | 32 | Address being fetched this cycle |
| lookup_hit | output | 1 | Selected row is valid and its tag matches |
| predicted_target | output | 32 | Stored landing address on a hit, zero on a miss |
| next_pc | output | 32 | Address to fetch next: stored target on a hit, fetch_pc + 4 otherwise |
| update_valid | input | 1 | A branch has resolved taken; write its row this cycle |
| update_pc | input | 32 | Address of the resolved taken branch |
| update_target | input | 32 | Landing address of the resolved taken branch |

## Verification
The bench drives lookups against an empty table, against rows it has just written, and against addresses that share a row but differ in tag. Together these separate a correct tag compare from one that checks only the valid bit or only the row. Writes to rows 0, 1 and 63 show whether the row decode covers the full field without spilling into neighbours. Lookups with nonzero low address bits, a miss at the top of the address space, a same-cycle write and lookup, and a write attempt with `update_valid` low each isolate a single rule: offset masking, wrapping of the sequential sum, read-before-write ordering, and the write enable.

// File: rtl/btb_pkg.sv
package btb_pkg;
    localparam int unsigned PC_W        = 32;
    localparam int unsigned ROWS        = 64;
    localparam int unsigned INSTR_BYTES = 4;
    localparam int unsigned OFS_W       = $clog2(INSTR_BYTES);
    localparam int unsigned IDX_W       = $clog2(ROWS);
    localparam int unsigned TAG_W       = PC_W - IDX_W - OFS_W;

    typedef logic [PC_W-1:0]  pc_t;
    typedef logic [IDX_W-1:0] idx_t;
    typedef logic [TAG_W-1:0] tag_t;

    typedef struct packed {
        logic valid;
        tag_t tag;
        pc_t  target;
    } entry_t;
endpackage

// File: rtl/btb_pc_fields.sv
module btb_pc_fields
    import btb_pkg::*;
(
    input  pc_t  pc,
    output idx_t row_idx,
    output tag_t row_tag
);
    // Byte offset within an instruction word plays no part in the table.
    logic unused_offset;
    assign unused_offset = ^pc[OFS_W-1:0];

    assign row_idx = pc[OFS_W +: IDX_W];
    assign row_tag = pc[PC_W-1 -: TAG_W];
endmodule

// File: rtl/btb_store.sv
module btb_store
    import btb_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   wr_en,
    input  idx_t   wr_idx,
    input  tag_t   wr_tag,
    input  pc_t    wr_target,
    input  idx_t   rd_idx,
    output entry_t rd_entry
);
    logic [ROWS-1:0] row_we;
    logic [ROWS-1:0] valid_q;
    tag_t            tag_q [ROWS];
    pc_t             tgt_q [ROWS];

    // One write strobe per row.
    for (genvar g = 0; g < ROWS; g++) begin : g_row_we
        assign row_we[g] = wr_en && (wr_idx == idx_t'(g));
    end

    // Only the valid bits carry a reset; payload is qualified by them.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) valid_q <= '0;
        else        valid_q <= valid_q | row_we;
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < ROWS; i++) begin
            if (row_we[i]) begin
                tag_q[i] <= wr_tag;
                tgt_q[i] <= wr_target;
            end
        end
    end

    // Read port sees registered contents: read-before-write on a shared row.
    assign rd_entry = '{valid: valid_q[rd_idx], tag: tag_q[rd_idx], target: tgt_q[rd_idx]};

    p_reset_clears_r1: assert property (@(posedge clk)
        !rst_n |=> (valid_q == '0));

    p_write_lands_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (valid_q[$past(wr_idx)] && (tgt_q[$past(wr_idx)] == $past(wr_target))
                   && (tag_q[$past(wr_idx)] == $past(wr_tag))));

    p_single_row_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(row_we));

    p_idle_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(valid_q));
endmodule

// File: rtl/btb_select.sv
module btb_select
    import btb_pkg::*;
(
    input  entry_t ent,
    input  tag_t   look_tag,
    input  pc_t    look_pc,
    output logic   hit,
    output pc_t    pred_target,
    output pc_t    next_addr
);
    pc_t seq_addr;

    assign seq_addr = look_pc + pc_t'(INSTR_BYTES);

    always_comb begin
        hit         = ent.valid && (ent.tag == look_tag);
        pred_target = hit ? ent.target : '0;
        next_addr   = hit ? ent.target : seq_addr;
    end
endmodule

// File: rtl/btb_direct.sv
module btb_direct
    import btb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PC_W-1:0]   fetch_pc,
    output logic              lookup_hit,
    output logic [PC_W-1:0]   predicted_target,
    output logic [PC_W-1:0]   next_pc,
    input  logic              update_valid,
    input  logic [PC_W-1:0]   update_pc,
    input  logic [PC_W-1:0]   update_target
);
    idx_t   look_idx, upd_idx;
    tag_t   look_tag, upd_tag;
    entry_t look_ent;

    btb_pc_fields u_look_fields (.pc(fetch_pc),  .row_idx(look_idx), .row_tag(look_tag));
    btb_pc_fields u_upd_fields  (.pc(update_pc), .row_idx(upd_idx),  .row_tag(upd_tag));

    btb_store u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (update_valid),
        .wr_idx    (upd_idx),
        .wr_tag    (upd_tag),
        .wr_target (update_target),
        .rd_idx    (look_idx),
        .rd_entry  (look_ent)
    );

    btb_select u_select (
        .ent         (look_ent),
        .look_tag    (look_tag),
        .look_pc     (fetch_pc),
        .hit         (lookup_hit),
        .pred_target (predicted_target),
        .next_addr   (next_pc)
    );

    // A just-written word address must hit with its target on the next cycle.
    p_fresh_write_hits_r3: assert property (@(posedge clk) disable iff (!rst_n)
        update_valid |=> (!(fetch_pc[PC_W-1:OFS_W] == $past(update_pc[PC_W-1:OFS_W]))
                          || (lookup_hit && (next_pc == $past(update_target)))));

    // Same row, different tag than the write just done: must miss and fall through.
    p_alias_misses_r5: assert property (@(posedge clk) disable iff (!rst_n)
        update_valid |=> (!((fetch_pc[OFS_W +: IDX_W] == $past(update_pc[OFS_W +: IDX_W]))
                            && (fetch_pc[PC_W-1 -: TAG_W] != $past(update_pc[PC_W-1 -: TAG_W])))
                          || (!lookup_hit && (next_pc == fetch_pc + 32'd4))));
endmodule

// File: tb/btb_direct_tb_top.sv
`timescale 1ns/1ps
module btb_direct_tb_top;
    import btb_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] fetch_pc = '0;
    logic        lookup_hit;
    logic [31:0] predicted_target, next_pc;
    logic        update_valid = 1'b0;
    logic [31:0] update_pc = '0, update_target = '0;

    always #2 clk = ~clk;  // 250 MHz

    btb_direct dut_i (
        .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc), .lookup_hit(lookup_hit),
        .predicted_target(predicted_target), .next_pc(next_pc),
        .update_valid(update_valid), .update_pc(update_pc), .update_target(update_target)
    );

    typedef struct {
        logic [31:0] pc;
        logic        hit;
        logic [31:0] tgt;
        logic [31:0] nxt;
        string       req;
    } exp_t;

    exp_t  sb_q[$];
    event  sample_ev;
    int    n_tests = 0;
    int    n_fail  = 0;
    bit    done    = 0;

    // Reference table built from the requirements.
    bit          ref_v [64];
    logic [23:0] ref_t [64];
    logic [31:0] ref_g [64];

    function automatic exp_t predict(input logic [31:0] pc, input string req);
        exp_t e;
        int   r;
        r = int'(pc[7:2]);
        e.pc  = pc;
        e.req = req;
        e.hit = ref_v[r] && (ref_t[r] == pc[31:8]);
        e.tgt = e.hit ? ref_g[r] : 32'h0;
        e.nxt = e.hit ? ref_g[r] : pc + 32'd4;
        return e;
    endfunction

    function automatic void ref_write(input logic [31:0] pc, input logic [31:0] tgt);
        ref_v[int'(pc[7:2])] = 1'b1;
        ref_t[int'(pc[7:2])] = pc[31:8];
        ref_g[int'(pc[7:2])] = tgt;
    endfunction

    // Driver tasks
    task automatic look(input logic [31:0] pc, input string req);
        @(negedge clk);
        fetch_pc = pc;
        sb_q.push_back(predict(pc, req));
        #1 -> sample_ev;
    endtask

    task automatic write(input logic [31:0] pc, input logic [31:0] tgt);
        @(negedge clk);
        update_valid = 1'b1; update_pc = pc; update_target = tgt;
        @(posedge clk);
        ref_write(pc, tgt);
        #1 update_valid = 1'b0;
    endtask

    task automatic write_and_look(input logic [31:0] upc, input logic [31:0] tgt,
                                  input logic [31:0] lpc, input string req);
        @(negedge clk);
        update_valid = 1'b1; update_pc = upc; update_target = tgt;
        fetch_pc = lpc;
        sb_q.push_back(predict(lpc, req));  // old contents expected
        #1 -> sample_ev;
        @(posedge clk);
        ref_write(upc, tgt);
        #1 update_valid = 1'b0;
    endtask

    task automatic disabled_write(input logic [31:0] pc, input logic [31:0] tgt);
        @(negedge clk);
        update_valid = 1'b0; update_pc = pc; update_target = tgt;
        @(posedge clk);
        #1;
    endtask

    // Monitor: pop and compare
    initial begin
        exp_t e;
        forever begin
            @(sample_ev);
            e = sb_q.pop_front();
            n_tests++;
            if (lookup_hit !== e.hit || predicted_target !== e.tgt || next_pc !== e.nxt) begin
                n_fail++;
                $display("FAIL %s pc=%h actual hit=%b tgt=%h next=%h expected hit=%b tgt=%h next=%h",
                         e.req, e.pc, lookup_hit, predicted_target, next_pc, e.hit, e.tgt, e.nxt);
            end
        end
    end

    // Watchdog
    initial begin
        #(4 * 200000);
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 64; i++) begin
            ref_v[i] = 1'b0; ref_t[i] = '0; ref_g[i] = '0;
        end
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: empty table after reset
        look(32'h0000_1000, "R1");
        look(32'h0000_20FC, "R1");
        // R2: miss falls through, including wrap at the top
        look(32'h1234_5678, "R2");
        look(32'hFFFF_FFFC, "R2");
        // R3: write then hit
        write(32'h0000_1000, 32'h0000_4000);
        look(32'h0000_1000, "R3");
        // R4: neighbouring rows are independent; last row
        write(32'h0000_1004, 32'h0000_5000);
        write(32'h0000_10FC, 32'h0000_9000);
        look(32'h0000_1000, "R4");
        look(32'h0000_1004, "R4");
        look(32'h0000_10FC, "R4");
        look(32'h0000_1008, "R4");
        // R5: same row, other tag misses
        look(32'h0000_2000, "R5");
        look(32'h8000_1000, "R5");
        // R6: alias write replaces
        write(32'h0000_2000, 32'h0000_6000);
        look(32'h0000_1000, "R6");
        look(32'h0000_2000, "R6");
        // R7: low bits ignored
        look(32'h0000_2003, "R7");
        write(32'h0000_3006, 32'h0000_7770);
        look(32'h0000_3004, "R7");
        look(32'h0000_7001, "R7");
        // R8: same-cycle write and lookup sees old contents
        write_and_look(32'h0000_1000, 32'h0000_8000, 32'h0000_1000, "R8");
        look(32'h0000_1000, "R8");
        write_and_look(32'h0000_1004, 32'h0000_5550, 32'h0000_1004, "R8");
        look(32'h0000_1004, "R8");
        // R9: write enable low changes nothing
        disabled_write(32'h0000_1040, 32'h0000_ABC0);
        look(32'h0000_1040, "R9");
        disabled_write(32'h0000_1000, 32'h0000_DEAD);
        look(32'h0000_1000, "R9");

        repeat (2) @(posedge clk);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule